// File: doc/BRIEF.md
# Store Queue with Issue Tracking

This block is an in-order buffer of pending memory stores for a data cache. Each entry holds one store, an address and a data word. New stores enter at the tail. The oldest store is shown at the head and is handed to the cache controller through a separate issue step. That step marks the head as in flight but leaves it in the buffer. The store leaves only when the controller reports that it has committed, through a dequeue. A store that hits in the cache can be issued and retired in the same cycle.

A combinational lookup port lets a younger load take forwarded data. Given an address, it returns the data of the youngest buffered store to that address, or reports a miss. A store being written in the current cycle is not seen by the lookup until the following cycle. Status outputs report whether the buffer is non-empty, not full, and whether the head is currently issued.

Top module: `stbuf_top`

## Requirements
- R1: After reset the buffer holds no stores: `not_empty` is 0, `not_full` is 1, `is_issued` is 0 and `srch_hit` is 0.
- R2: Stores leave in the order they were accepted. While `not_empty` is 1, `head_addr` and `head_data` show the oldest store still held.
- R3: `issue_grant` is 1 in a cycle exactly when `issue_req` is 1, the buffer is non-empty and `is_issued` is 0. A granted issue without a dequeue sets `is_issued` from the next cycle and leaves the head in place.
- R4: While `is_issued` is 1, `issue_grant` stays 0 and the issued state is held until a dequeue.
- R5: A dequeue on a non-empty buffer removes the head and clears `is_issued` from the next cycle. The next older store then appears at the head.
- R6: An issue and a dequeue in the same cycle both take effect. The grant is 1, the head retires, and `is_issued` is 0 in the next cycle.
- R7: `srch_hit` is 1 when any held store has address `srch_addr`. `srch_data` is then the data of the youngest such store. `srch_hit` is 0 when no held store matches.
- R8: A store accepted in the current cycle is not visible to the lookup in that cycle. It is visible from the next cycle.
- R9: An enqueue while the buffer holds DEPTH stores is refused and has no effect, even when a dequeue happens in the same cycle.
- R10: A dequeue or an issue request on an empty buffer is ignored, and `issue_grant` stays 0.
- R11: `not_full` is 0 exactly when DEPTH stores are held. Read and write positions wrap modulo DEPTH without losing order.
- R12: An enqueue accepted in the same cycle as an issue or a dequeue is stored together with that operation, with no conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Append a store this cycle |
| enq_addr | input | AW | Address of the appended store |
| enq_data | input | DW | Data of the appended store |
| issue_req | input | 1 | Controller asks to issue the head store |
| issue_grant | output | 1 | Issue accepted this cycle |
| head_addr | output | AW | Address of the oldest store |
| head_data | output | DW | Data of the oldest store |
| deq_req | input | 1 | Head store has committed; retire it |
| srch_addr | input | AW | Lookup address for forwarding |
| srch_hit | output | 1 | Some held store matches the lookup address |
| srch_data | output | DW | Data of the youngest matching store |
| not_empty | output | 1 | At least one store held |
| not_full | output | 1 | Fewer than DEPTH stores held |
| is_issued | output | 1 | Head store has been issued and not retired |

## Verification
The hardest case to reach is a youngest-match lookup while the buffer has wrapped. Here several entries share an address, the head index is non-zero, and a same-address store is entering in the same cycle. Reaching it needs many enqueue and dequeue rounds driven through a full buffer. A long seeded random sweep does this over four addresses and a four-entry buffer, with enqueue weighted above dequeue so the buffer often fills and wraps. A bench-side ordered model gives the expected head, lookup result and flags in every cycle. Directed sequences run first to cover refused operations at full and empty, and issue with dequeue in one cycle.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

  typedef struct packed {
    logic enq;
    logic iss;
    logic deq;
  } fire_t;

  function automatic int ring_add(input int base, input int off, input int depth);
    int s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/stbuf_ctrl.sv
module stbuf_ctrl
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  input  logic          issue_req,
  input  logic          deq_req,
  output fire_t         fire,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          issued
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic          empty, full, upd;
  logic [PW-1:0] head_nx, tail_nx;
  logic [CW-1:0] count_nx;
  logic          issued_nx;

  always_comb begin
    empty    = (count == '0);
    full     = (count == FULL);
    fire.enq = enq_valid && !full;
    fire.deq = deq_req && !empty;
    fire.iss = issue_req && !empty && !issued;
    upd      = fire.enq | fire.deq | fire.iss;

    head_nx  = head;
    tail_nx  = tail;
    if (fire.deq) head_nx = (head == LAST) ? '0 : head + 1'b1;
    if (fire.enq) tail_nx = (tail == LAST) ? '0 : tail + 1'b1;
    count_nx = count + CW'(fire.enq) - CW'(fire.deq);

    issued_nx = issued;
    if (fire.deq)      issued_nx = 1'b0;
    else if (fire.iss) issued_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      count  <= '0;
      issued <= 1'b0;
    end else if (upd) begin
      head   <= head_nx;
      tail   <= tail_nx;
      count  <= count_nx;
      issued <= issued_nx;
    end
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  p_issue_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_req && !issued && !empty && !deq_req |=> issued);
  p_issued_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issued && !deq_req |=> issued);
  p_deq_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    deq_req |=> !issued);
  p_empty_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !issued);
  p_full_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full && !deq_req |=> (count == FULL));
  p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !deq_req |=> $stable(head));

endmodule

// File: rtl/stbuf_store.sv
module stbuf_store #(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_ptr,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_ptr,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] slot_addr [DEPTH],
  output logic [DW-1:0] slot_data [DEPTH]
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic we;
    assign we = wr_en && (wr_ptr == PW'(i));
    always_ff @(posedge clk) begin
      if (we) begin
        slot_addr[i] <= wr_addr;
        slot_data[i] <= wr_data;
      end
    end
  end

  assign rd_addr = slot_addr[rd_ptr];
  assign rd_data = slot_data[rd_ptr];

endmodule

// File: rtl/stbuf_search.sv
module stbuf_search
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int CW    = 3,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic [AW-1:0] slot_addr [DEPTH],
  input  logic [DW-1:0] slot_data [DEPTH],
  input  logic [PW-1:0] head,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] key,
  output logic          hit,
  output logic [DW-1:0] data
);

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    int idx;
    hit  = 1'b0;
    data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = ring_add(int'(head), k, DEPTH);
      if ((k < int'(count)) && (slot_addr[idx[PW-1:0]] == key)) begin
        hit  = 1'b1;
        data = slot_data[idx[PW-1:0]];
      end
    end
  end

endmodule

// File: rtl/stbuf_top.sv
module stbuf_top
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  input  logic [AW-1:0] enq_addr,
  input  logic [DW-1:0] enq_data,
  input  logic          issue_req,
  output logic          issue_grant,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  input  logic          deq_req,
  input  logic [AW-1:0] srch_addr,
  output logic          srch_hit,
  output logic [DW-1:0] srch_data,
  output logic          not_empty,
  output logic          not_full,
  output logic          is_issued
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  fire_t         fire;
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];

  stbuf_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid),
    .issue_req (issue_req),
    .deq_req   (deq_req),
    .fire      (fire),
    .head      (head),
    .tail      (tail),
    .count     (count),
    .issued    (is_issued)
  );

  stbuf_store #(.DEPTH(DEPTH), .PW(PW), .AW(AW), .DW(DW)) u_store (
    .clk       (clk),
    .wr_en     (fire.enq),
    .wr_ptr    (tail),
    .wr_addr   (enq_addr),
    .wr_data   (enq_data),
    .rd_ptr    (head),
    .rd_addr   (head_addr),
    .rd_data   (head_data),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  stbuf_search #(.DEPTH(DEPTH), .PW(PW), .CW(CW), .AW(AW), .DW(DW)) u_search (
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .head      (head),
    .count     (count),
    .key       (srch_addr),
    .hit       (srch_hit),
    .data      (srch_data)
  );

  assign issue_grant = fire.iss;
  assign not_empty   = (count != '0);
  assign not_full    = (count != CW'(DEPTH));

  p_srch_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty |-> !srch_hit);
  p_grant_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_issued |-> !issue_grant);
  p_iss_deq_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_grant && deq_req |=> !is_issued);
  p_empty_nogrant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty |-> !issue_grant);

endmodule

// File: tb/sim_stbuf_top.sv
`timescale 1ns/1ps
module sim_stbuf_top;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0, issue_req = 1'b0, deq_req = 1'b0;
  logic [AW-1:0] enq_addr = '0, srch_addr = '0;
  logic [DW-1:0] enq_data = '0;
  logic issue_grant, srch_hit, not_empty, not_full, is_issued;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, srch_data;

  always #2.5 clk = ~clk;

  stbuf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_addr(enq_addr),
    .enq_data(enq_data), .issue_req(issue_req), .issue_grant(issue_grant),
    .head_addr(head_addr), .head_data(head_data), .deq_req(deq_req),
    .srch_addr(srch_addr), .srch_hit(srch_hit), .srch_data(srch_data),
    .not_empty(not_empty), .not_full(not_full), .is_issued(is_issued));

  int total = 0;
  int bad = 0;
  logic [AW-1:0] m_a[$];
  logic [DW-1:0] m_d[$];
  logic m_iss = 1'b0;
  string ftag = "R1";

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic e, input logic [AW-1:0] ea, input logic [DW-1:0] ed,
                     input logic i, input logic d, input logic [AW-1:0] sa);
    logic eg, eh, eacc, dacc;
    logic [DW-1:0] ed_s;
    @(negedge clk);
    chk(ftag, "not_empty", 64'(not_empty), 64'(m_a.size() > 0));
    chk(ftag, "not_full", 64'(not_full), 64'(m_a.size() < DEPTH));
    chk(ftag, "is_issued", 64'(is_issued), 64'(m_iss));
    enq_valid = e; enq_addr = ea; enq_data = ed;
    issue_req = i; deq_req = d; srch_addr = sa;
    #1;
    eg = i && (m_a.size() > 0) && !m_iss;
    chk(m_iss ? "R4" : (m_a.size() == 0 ? "R10" : (d ? "R6" : "R3")),
        "issue_grant", 64'(issue_grant), 64'(eg));
    if (m_a.size() > 0) begin
      chk("R2", "head_addr", 64'(head_addr), 64'(m_a[0]));
      chk("R2", "head_data", 64'(head_data), 64'(m_d[0]));
    end
    eh = 1'b0; ed_s = '0;
    foreach (m_a[k]) if (m_a[k] == sa) begin eh = 1'b1; ed_s = m_d[k]; end
    chk((e && ea == sa) ? "R8" : "R7", "srch_hit", 64'(srch_hit), 64'(eh));
    if (eh) chk("R7", "srch_data", 64'(srch_data), 64'(ed_s));
    @(posedge clk);
    eacc = e && (m_a.size() < DEPTH);
    dacc = d && (m_a.size() > 0);
    if (e && m_a.size() == DEPTH) ftag = "R9";
    else if ((d || i) && m_a.size() == 0) ftag = "R10";
    else if (eacc && (dacc || eg)) ftag = "R12";
    else if (dacc && eg) ftag = "R6";
    else if (dacc) ftag = "R5";
    else if (eg) ftag = "R3";
    else ftag = "R11";
    if (dacc) begin void'(m_a.pop_front()); void'(m_d.pop_front()); m_iss = 1'b0; end
    else if (eg) m_iss = 1'b1;
    if (eacc) begin m_a.push_back(ea); m_d.push_back(ed); end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "not_empty", 64'(not_empty), 64'(0));
    chk("R1", "not_full", 64'(not_full), 64'(1));
    chk("R1", "is_issued", 64'(is_issued), 64'(0));
    chk("R1", "srch_hit", 64'(srch_hit), 64'(0));
    rst_n = 1'b1;
    // R10: operations on empty buffer are ignored
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 1, 0);
    // R8/R11: fill with repeated address, refuse fifth (R9)
    cyc(1, 10, 100, 0, 0, 10);
    cyc(1, 11, 101, 0, 0, 10);
    cyc(1, 10, 102, 0, 0, 10);
    cyc(1, 12, 103, 0, 0, 10);
    cyc(1, 13, 104, 0, 0, 13);
    cyc(1, 13, 105, 0, 1, 13);
    cyc(0, 0, 0, 0, 0, 10);
    // R3/R4: issue, then blocked re-issue, then dequeue (R5)
    cyc(0, 0, 0, 1, 0, 11);
    cyc(0, 0, 0, 1, 0, 11);
    cyc(0, 0, 0, 1, 1, 10);
    // R6: issue and dequeue together; R12: enqueue with issue
    cyc(0, 0, 0, 1, 1, 10);
    cyc(1, 20, 200, 1, 0, 20);
    cyc(1, 21, 201, 0, 1, 20);
    cyc(0, 0, 0, 1, 1, 21);
    cyc(0, 0, 0, 0, 1, 21);
    cyc(0, 0, 0, 0, 1, 21);
    cyc(0, 0, 0, 1, 1, 21);
    // Wrapped random sweep over a small address set
    for (int n = 0; n < 6000; n++) begin
      logic [AW-1:0] a, s;
      int r;
      r = $urandom(seed); seed = seed + 1;
      a = AW'(r % 4);
      s = AW'((r >> 4) % 4);
      cyc(((r >> 8) % 10) < 6, a, DW'(n), ((r >> 12) % 3) == 0,
          ((r >> 16) % 10) < 4, s);
    end
    cyc(0, 0, 0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule